// File: doc/BRIEF.md
# Stereo Limiter Gain Controller

This block is the control half of a stereo peak limiter. It sees a stream of signed left/right sample pairs taken after the volume stage and keeps one attenuation code per channel. When either channel's magnitude reaches a selectable detection level, it lowers a common target code by a selectable number of 0.375 dB steps. Each channel then takes that target at its own next zero crossing. If no crossing arrives in time, a sample-count timeout forces the change. A second mode drops the zero-crossing wait: the codes fall by exactly one step on every offending sample. The block only lowers gain. Raising gain again, the multiplier and path steering are handled elsewhere.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `s_ready` is tied high, every cycle with `s_valid` high is one sample period, and cycles with `s_valid` low count for nothing. Configuration inputs are plain levels and are sampled on each clock edge.

Top module: `alc_limiter_top`

## Requirements
- R1: One attenuation decision yields a single target code that both channel codes take. When several samples arrive in a row with `zc_off` high, `gain_l` equals `gain_r`.
- R2: A channel is over the limit when its magnitude is at or above the level picked by `thr_sel`. For 16-bit samples the levels are 0 → 24571 (−2.5 dBFS), 1 → 20437 (−4.1 dBFS), 2 → 16422 (−6.0 dBFS) and 3 → 12315 (−8.5 dBFS). A sample of −32768 counts as magnitude 32767.
- R3: In zero-cross mode, a decision sets target = current lower code minus 1, 2, 4 or 8 for `step_sel` 0..3. The result saturates at 0, and codes never rise.
- R4: In zero-cross mode (`zc_off`=0), the decision is taken on one sample. A pending channel takes the target on a later sample whose sign bit differs from that channel's previous accepted sample, or whose value is exactly 0. The update is visible after that sample's clock edge.
- R5: If no crossing occurs, a pending channel takes the target on the T-th accepted sample after the decision, where T = 128 << `tmo_sel`.
- R6: With `zc_off`=1, each over-limit sample lowers both codes by exactly one step, whatever `step_sel` says. The new codes are visible after that sample's edge.
- R7: No new decision is taken while either channel still has a pending update. Once both have applied it, the next over-limit sample triggers a new decision.
- R8: While `en` is low the codes hold, and any pending update and its timeout count are discarded.
- R9: Samples below the level on both channels start no attenuation.
- R10: `s_ready` is always 1. After reset both codes are 200 (`GAIN_INIT`). Cycles with `s_valid` low advance no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Limiter enable |
| thr_sel | input | 2 | Detection level select |
| step_sel | input | 2 | Steps per decision (zero-cross mode) |
| tmo_sel | input | 2 | Zero-crossing timeout select |
| zc_off | input | 1 | 1: immediate one-step mode |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Always 1 |
| s_left | input | SW | Left sample, two's complement |
| s_right | input | SW | Right sample, two's complement |
| gain_l | output | GW | Left applied gain code |
| gain_r | output | GW | Right applied gain code |

## Verification
The bench probes each level exactly one LSB below and at its threshold, plus the −32768 sample. A wrong compare or an unsaturated absolute value would show up as one step too many or too few. It lets one channel cross while the other waits, and keeps the input over the limit meanwhile. A design that re-decided early would drift the codes apart. Timeouts are driven with idle gaps in the stream, where an off-by-one or counting of idle cycles moves the update by a sample. Long runs at 8 steps push the codes to 0, where wrap-around would show as a jump to a high code.

// File: rtl/alc_pkg.sv
package alc_pkg;

  // Q16 linear fractions of full scale for the four detection levels
  function automatic longint unsigned lvl_limit(input int unsigned sw, input int unsigned sel);
    longint unsigned fs;
    longint unsigned k;
    fs = (64'd1 << (sw - 1)) - 64'd1;
    case (sel)
      0:       k = 64'd49145;
      1:       k = 64'd40877;
      2:       k = 64'd32846;
      default: k = 64'd24631;
    endcase
    return (fs * k) >> 16;
  endfunction

endpackage

// File: rtl/alc_level_det.sv
module alc_level_det #(
  parameter int SW = 16
) (
  input  logic [SW-1:0] smp,
  input  logic [1:0]    sel,
  output logic          over
);
  localparam logic [SW-1:0] MAXV = {1'b0, {(SW-1){1'b1}}};
  localparam logic [SW-1:0] MINV = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-1:0] LV0 = SW'(alc_pkg::lvl_limit(SW, 0));
  localparam logic [SW-1:0] LV1 = SW'(alc_pkg::lvl_limit(SW, 1));
  localparam logic [SW-1:0] LV2 = SW'(alc_pkg::lvl_limit(SW, 2));
  localparam logic [SW-1:0] LV3 = SW'(alc_pkg::lvl_limit(SW, 3));

  logic [SW-1:0] mag;
  logic [SW-1:0] lvl;

  always_comb begin
    if (!smp[SW-1])      mag = smp;
    else if (smp == MINV) mag = MAXV;
    else                  mag = (~smp) + 1'b1;
    case (sel)
      2'd0:    lvl = LV0;
      2'd1:    lvl = LV1;
      2'd2:    lvl = LV2;
      default: lvl = LV3;
    endcase
  end

  assign over = (mag >= lvl);

  always_comb begin
    AST_MAG_IN_RANGE: assert (mag <= MAXV); // R2
  end
endmodule

// File: rtl/alc_zc_apply.sv
module alc_zc_apply #(
  parameter int SW = 16,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          step_en,
  input  logic          clr,
  input  logic          arm,
  input  logic [CW-1:0] lim,
  input  logic [SW-1:0] smp,
  output logic          pend,
  output logic          fire
);
  logic          prev_neg_q;
  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic          zc;
  logic          tmo;

  assign zc   = (smp[SW-1] != prev_neg_q) || (smp == '0);
  assign tmo  = ({1'b0, cnt_q} + 1'b1) >= {1'b0, lim};
  assign fire = step_en && pend_q && (zc || tmo);
  assign pend = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_neg_q <= 1'b0;
      pend_q     <= 1'b0;
      cnt_q      <= '0;
    end else begin
      if (smp_vld) prev_neg_q <= smp[SW-1];
      if (clr) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else if (arm) begin
        pend_q <= 1'b1;
        cnt_q  <= '0;
      end else if (fire) begin
        pend_q <= 1'b0;
      end else if (step_en && pend_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_ARM_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !pend_q); // R7
  AST_FIRE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr) |=> !pend_q); // R4
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!pend_q && cnt_q == '0)); // R8
endmodule

// File: rtl/alc_limiter_top.sv
module alc_limiter_top #(
  parameter int SW        = 16,
  parameter int GW        = 8,
  parameter int GAIN_INIT = 200,
  parameter int TMO_BASE  = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    thr_sel,
  input  logic [1:0]    step_sel,
  input  logic [1:0]    tmo_sel,
  input  logic          zc_off,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [SW-1:0] s_left,
  input  logic [SW-1:0] s_right,
  output logic [GW-1:0] gain_l,
  output logic [GW-1:0] gain_r
);
  localparam int CW = $clog2(TMO_BASE * 8) + 1;
  localparam logic [GW-1:0] G0 = GW'(GAIN_INIT);

  logic          run, zc_run, imm_upd, arm, clr, any_p, over_any;
  logic [1:0]    over_c, pend_c, fire_c;
  logic [SW-1:0] smp_c [2];
  logic [GW-1:0] gl_q, gr_q, tgt_q, gmin, base, imm_val, step;
  logic [CW-1:0] lim;

  function automatic logic [GW-1:0] sat_sub(input logic [GW-1:0] a, input logic [GW-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  assign s_ready  = 1'b1;
  assign smp_c[0] = s_left;
  assign smp_c[1] = s_right;
  assign run      = s_valid && en;
  assign zc_run   = run && !zc_off;
  assign imm_upd  = run && zc_off;
  assign over_any = |over_c;
  assign any_p    = |pend_c;
  assign arm      = zc_run && !any_p && over_any;
  assign clr      = !en || imm_upd;
  assign lim      = CW'(TMO_BASE) << tmo_sel;
  assign step     = GW'(1) << step_sel;
  assign gmin     = (gl_q < gr_q) ? gl_q : gr_q;
  assign base     = any_p ? tgt_q : gmin;
  assign imm_val  = over_any ? sat_sub(base, GW'(1)) : base;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    alc_level_det #(.SW(SW)) u_det (
      .smp  (smp_c[ch]),
      .sel  (thr_sel),
      .over (over_c[ch])
    );
    alc_zc_apply #(.SW(SW), .CW(CW)) u_zc (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_vld (s_valid),
      .step_en (zc_run),
      .clr     (clr),
      .arm     (arm),
      .lim     (lim),
      .smp     (smp_c[ch]),
      .pend    (pend_c[ch]),
      .fire    (fire_c[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gl_q  <= G0;
      gr_q  <= G0;
      tgt_q <= '0;
    end else begin
      if (imm_upd) begin
        gl_q <= imm_val;
        gr_q <= imm_val;
      end else begin
        if (fire_c[0]) gl_q <= tgt_q;
        if (fire_c[1]) gr_q <= tgt_q;
      end
      if (arm) tgt_q <= sat_sub(gmin, step);
    end
  end

  assign gain_l = gl_q;
  assign gain_r = gr_q;

  AST_NO_RISE_L: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gain_l <= $past(gain_l)); // R3
  AST_NO_RISE_R: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gain_r <= $past(gain_r)); // R3
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gain_l == $past(gain_l) && gain_r == $past(gain_r))); // R8
  AST_IMM_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    imm_upd |=> gain_l == gain_r); // R1
  AST_IMM_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_upd && !any_p && gl_q == gr_q) |=>
      (gain_l == $past(gain_l) || gain_l == $past(gain_l) - 1'b1)); // R6
  AST_QUIET_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !over_any && !any_p) |=> (gain_l == $past(gain_l) && gain_r == $past(gain_r))); // R9
endmodule

// File: tb/sim_alc_limiter_top.sv
module sim_alc_limiter_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic [1:0]  thr_sel = 2'd0, step_sel = 2'd0, tmo_sel = 2'd0;
  logic        zc_off = 1'b1;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_left = '0, s_right = '0;
  logic [7:0]  gain_l, gain_r;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [7:0] gl;
    logic [7:0] gr;
    string      tag;
  } exp_t;
  exp_t q[$];

  // reference state, derived from the requirements
  int m_gl = 200, m_gr = 200, m_tgt = 0, m_cl = 0, m_cr = 0;
  bit m_pl = 0, m_pr = 0, m_nl = 0, m_nr = 0;

  always #(CLK_P/2) clk = ~clk;

  alc_limiter_top u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .thr_sel(thr_sel), .step_sel(step_sel),
    .tmo_sel(tmo_sel), .zc_off(zc_off), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .gain_l(gain_l), .gain_r(gain_r)
  );

  function automatic int lvl(input logic [1:0] sel);
    case (sel)
      2'd0: return 24571;
      2'd1: return 20437;
      2'd2: return 16422;
      default: return 12315;
    endcase
  endfunction

  function automatic bit is_over(input logic [15:0] v);
    int m;
    m = $signed(v);
    if (m < 0) m = -m;
    if (m > 32767) m = 32767;
    return m >= lvl(thr_sel);
  endfunction

  function automatic int ssub(input int a, input int b);
    return (a > b) ? a - b : 0;
  endfunction

  task automatic model(input bit vld, input logic [15:0] l, input logic [15:0] r);
    bit ov, zl, zr;
    int base, g, lim;
    ov  = vld && (is_over(l) || is_over(r));
    zl  = (l[15] != m_nl) || (l == 0);
    zr  = (r[15] != m_nr) || (r == 0);
    lim = 128 << tmo_sel;
    if (!en) begin
      m_pl = 0; m_pr = 0; m_cl = 0; m_cr = 0;
    end else if (vld && zc_off) begin
      base = (m_pl || m_pr) ? m_tgt : ((m_gl < m_gr) ? m_gl : m_gr);
      g = ov ? ssub(base, 1) : base;
      m_gl = g; m_gr = g;
      m_pl = 0; m_pr = 0; m_cl = 0; m_cr = 0;
    end else if (vld) begin
      if (m_pl || m_pr) begin
        if (m_pl) begin
          if (zl || m_cl + 1 >= lim) begin m_gl = m_tgt; m_pl = 0; end
          else m_cl++;
        end
        if (m_pr) begin
          if (zr || m_cr + 1 >= lim) begin m_gr = m_tgt; m_pr = 0; end
          else m_cr++;
        end
      end else if (ov) begin
        m_tgt = ssub((m_gl < m_gr) ? m_gl : m_gr, 1 << step_sel);
        m_pl = 1; m_pr = 1; m_cl = 0; m_cr = 0;
      end
    end
    if (vld) begin m_nl = l[15]; m_nr = r[15]; end
  endtask

  // driver: one sample per call, expected codes pushed to the scoreboard
  task automatic send(input logic [15:0] l, input logic [15:0] r, input string tag);
    @(negedge clk);
    s_valid = 1'b1; s_left = l; s_right = r;
    model(1'b1, l, r);
    q.push_back('{gl: 8'(m_gl), gr: 8'(m_gr), tag: tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b0;
      model(1'b0, '0, '0);
    end
  endtask

  task automatic cfg(input bit e, input logic [1:0] th, input logic [1:0] st,
                     input logic [1:0] tm, input bit zo);
    @(negedge clk);
    s_valid = 1'b0;
    en = e; thr_sel = th; step_sel = st; tmo_sel = tm; zc_off = zo;
    model(1'b0, '0, '0);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compares results one sample edge after acceptance
  initial begin
    exp_t e;
    forever begin
      bit v;
      @(posedge clk);
      v = s_valid;
      @(negedge clk);
      #1;
      if (v && q.size() > 0) begin
        e = q.pop_front();
        chk(gain_l == e.gl, {e.tag, " left"}, int'(gain_l), int'(e.gl));
        chk(gain_r == e.gr, {e.tag, " right"}, int'(gain_r), int'(e.gr));
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 190000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state and ready
    chk(gain_l == 8'd200, "R10 reset left", int'(gain_l), 200);
    chk(gain_r == 8'd200, "R10 reset right", int'(gain_r), 200);
    chk(s_ready == 1'b1, "R10 ready", int'(s_ready), 1);

    // R9 / R2 boundaries, immediate mode R6
    cfg(1, 0, 0, 0, 1);
    send(16'd24570, 16'd0, "R9 below lvl0");
    send(16'd0, -16'sd24570, "R9 below lvl0 neg");
    send(16'd24571, 16'd0, "R2 at lvl0");
    send(16'd0, -16'sd24571, "R2 at lvl0 neg");
    cfg(1, 0, 3, 0, 1);
    send(16'h8000, 16'd0, "R2 min sample");
    for (int i = 0; i < 5; i++) send(16'd30000, 16'd30000, "R6 one step");
    cfg(1, 3, 0, 0, 1);
    send(16'd12314, 16'd12314, "R2 lvl3 below");
    send(16'd12315, 16'd0, "R2 lvl3 at");
    cfg(1, 1, 0, 0, 1);
    send(16'd20436, 16'd0, "R2 lvl1 below");
    send(16'd0, 16'd20437, "R2 lvl1 at R1");
    cfg(1, 2, 0, 0, 1);
    send(16'd16421, 16'd0, "R2 lvl2 below");
    send(16'd16422, 16'd16422, "R2 lvl2 at");

    // zero-cross mode R3 R4 R7
    cfg(1, 0, 2, 0, 0);
    send(16'd30000, 16'd30000, "R3 decision");
    send(16'd100, -16'sd100, "R4 right crosses");
    send(16'd20000, -16'sd25000, "R7 no redecide");
    send(16'd0, -16'sd5, "R4 left zero");
    send(16'd30000, -16'sd30000, "R7 retrigger");
    send(-16'sd10, -16'sd10, "R4 left crosses");
    send(-16'sd10, 16'd10, "R4 right crosses");

    // timeout R5 with both tmo settings and gaps R10
    send(16'd30000, 16'd30000, "R5 decision");
    for (int i = 0; i < 130; i++) send(16'd1000, 16'd1000, "R5 tmo128");
    cfg(1, 0, 1, 1, 0);
    send(16'd30000, 16'd30000, "R5 decision2");
    for (int i = 0; i < 258; i++) begin
      send(16'd1000, 16'd1000, "R5 tmo256 R10 gaps");
      if (i % 3 == 0) idle(2);
    end

    // enable low R8
    send(16'd30000, 16'd30000, "R8 decision");
    cfg(0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++) send(16'd30000, -16'sd30000, "R8 disabled");
    cfg(1, 0, 1, 0, 0);
    for (int i = 0; i < 140; i++) send(16'd500, 16'd500, "R8 pending dropped");

    // saturation R3
    cfg(1, 0, 3, 0, 0);
    for (int i = 0; i < 40; i++) begin
      send(16'd30000, 16'd30000, "R3 sat decide");
      send(-16'sd30000, -16'sd30000, "R3 sat apply");
    end
    cfg(1, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) send(16'd30000, 16'd30000, "R6 at zero");

    idle(3);
    chk(q.size() == 0, "scoreboard drain", q.size(), 0);
    finish_run();
  end
endmodule